// File: doc/BRIEF.md
# Register-List Memory Transfer Sequencer

This block carries out a multi-register load or store as a single operation. The caller supplies four things: a 16-bit selection mask, a byte start address, a 3-bit addressing-mode code and a size flag. The block then runs word-wide bus cycles, one after another, on a request/acknowledge memory port. It reads stored values from a 16-entry register file port, or writes loaded values back to it. It produces every bus address itself and decides the order in which registers are visited.

A load always walks memory upward from the start address. After the last selected register it issues one more word read, whose data is discarded. A store in predecrement mode (code 4) walks downward and visits registers from index 15 toward index 0. A store in any other mode walks upward in index order. At the end the block pulses `done` and presents the address where the walk stopped, so the caller can update a base register.

Top module: `regxfer_seq`

## Requirements
- R1: After reset, and whenever no operation is active, `busy`, `bus_req`, `done` and `rf_we` are all low.
- R2: A load (`to_mem`=0) reads words at `base_addr`, `base_addr`+2, `base_addr`+4 and so on, whatever the mode code.
- R3: Every load ends with one extra word read at the next ascending address, and that read writes no register. A load with an all-zero mask performs only that read.
- R4: In forward order, mask bit i selects register i (0–7 data, 8–15 address), and registers are visited from the lowest set bit upward.
- R5: A store with `amode`=4 writes its first word at `base_addr`-2 and each later word 2 bytes lower. Mask bit i selects register 15-i, visited from the lowest set bit upward.
- R6: A store with any other mode code writes at ascending addresses from `base_addr` in forward register order.
- R7: With `long_sz`=1, each register takes two word cycles, and the upper 16 bits sit at the lower address. A predecrement store therefore writes the lower half first.
- R8: A word-size load writes the register with the 16-bit value sign-extended to 32 bits.
- R9: `done` is high for exactly one cycle. With it, `final_addr` equals `base_addr` plus 2 per transferred word for ascending walks, or minus 2 per word for predecrement. The extra read is not counted. A store with an all-zero mask reports `base_addr`.
- R10: While `bus_req` is high and `bus_ack` is low, `bus_addr`, `bus_we` and, for writes, `bus_wdata` hold steady.
- R11: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| to_mem | input | 1 | 1 = store registers to memory, 0 = load |
| long_sz | input | 1 | 1 = 32-bit per register, 0 = 16-bit |
| amode | input | 3 | Addressing-mode code; 4 = predecrement |
| reg_mask | input | 16 | Register selection mask |
| base_addr | input | 32 | Byte start address |
| busy | output | 1 | Operation in progress |
| bus_req | output | 1 | Word bus cycle request |
| bus_we | output | 1 | 1 = write cycle |
| bus_addr | output | 32 | Byte address of the word cycle |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Completes the current bus cycle |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` |
| rf_ridx | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write strobe |
| rf_widx | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| done | output | 1 | One-cycle completion pulse |
| final_addr | output | 32 | Ending address, valid with `done` |

## Verification
The bench targets several corner cases of the walk:

- **Predecrement store.** A design that numbered registers forward would write the wrong values. One that started at `base_addr` instead of `base_addr`-2 would shift every word by one slot. One that kept the high-first half order would swap the halves of each long word.
- **Loads.** Each load is checked for the trailing discarded read. A design that dropped that read, wrote a register from it, or counted it in `final_addr` would show a missing bus item, a spurious write or an address 2 too high.
- **Zero mask.** Both directions are run with an empty mask. A design that reported the wrong address there, or skipped the extra read, would show a wrong `final_addr` or a missing bus item.
- **Negative words, slow acknowledges, stray start.** Word loads of negative values catch a missing sign extension. Acknowledge latency exposes a request that changes while it waits. A stray `start` in mid-operation would, if accepted, add unexpected bus cycles.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_EXTRA = 2'd2,
    ST_DONE  = 2'd3
  } xstate_t;

  localparam logic [2:0] MODE_PREDEC = 3'd4;

endpackage

// File: rtl/regxfer_pick.sv
// Finds the lowest pending mask bit and maps it to a register index,
// mirrored when the walk runs in reverse register order.
module regxfer_pick #(
  parameter int NREG = 16,
  parameter int IW   = 4
) (
  input  logic [NREG-1:0] mask,
  input  logic            rev,
  output logic            any,
  output logic [NREG-1:0] first_bit,
  output logic [IW-1:0]   reg_idx
);

  logic [NREG-1:0] low_iso;
  logic [IW-1:0]   pos;

  assign low_iso   = mask & (~mask + NREG'(1));
  assign any       = |mask;
  assign first_bit = low_iso;

  always_comb begin
    pos = '0;
    for (int i = 0; i < NREG; i++) begin
      if (low_iso[i]) pos = pos | IW'(i);
    end
  end

  assign reg_idx = rev ? (IW'(NREG - 1) - pos) : pos;

endmodule

// File: rtl/regxfer_addr.sv
// Address walker: holds the running boundary address; a descending walk
// presents boundary-STEP so the first word lands just below the start.
module regxfer_addr #(
  parameter int AW   = 32,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  input  logic          step_en,
  input  logic          down,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] cyc_addr
);

  logic [AW-1:0] cur_q, cur_d;
  logic          cur_en;

  always_comb begin
    cur_d  = cur_q;
    cur_en = load_en | step_en;
    if (load_en)      cur_d = load_val;
    else if (step_en) cur_d = down ? (cur_q - AW'(STEP)) : (cur_q + AW'(STEP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  assign cur_addr = cur_q;
  assign cyc_addr = down ? (cur_q - AW'(STEP)) : cur_q;

endmodule

// File: rtl/regxfer_lane.sv
// Data lane: chooses the store half-word, gathers load halves and
// registers the register-file write.
module regxfer_lane #(
  parameter int DW = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          long_sz,
  input  logic          hi_first,
  input  logic          half,
  input  logic [2*DW-1:0] rf_rdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          cap_hi,
  input  logic          commit,
  input  logic [IW-1:0] commit_idx,
  output logic [DW-1:0] wdata,
  output logic          rf_we,
  output logic [IW-1:0] rf_widx,
  output logic [2*DW-1:0] rf_wdata
);

  localparam int RW = 2 * DW;

  logic            sel_hi;
  logic [DW-1:0]   hi_q;
  logic [RW-1:0]   word_d;
  logic            we_q;
  logic [IW-1:0]   idx_q;
  logic [RW-1:0]   data_q;

  assign sel_hi = long_sz & (hi_first ? ~half : half);
  assign wdata  = sel_hi ? rf_rdata[RW-1:DW] : rf_rdata[DW-1:0];

  always_comb begin
    if (long_sz) word_d = {hi_q, bus_rdata};
    else         word_d = {{DW{bus_rdata[DW-1]}}, bus_rdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_q <= '0;
    else if (cap_hi) hi_q <= bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      data_q <= '0;
    end else if (commit) begin
      idx_q  <= commit_idx;
      data_q <= word_d;
    end
  end

  assign rf_we    = we_q;
  assign rf_widx  = idx_q;
  assign rf_wdata = data_q;

endmodule

// File: rtl/regxfer_seq.sv
module regxfer_seq
  import regxfer_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 16,
  parameter int NREG  = 16,
  parameter int MODEW = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     to_mem,
  input  logic                     long_sz,
  input  logic [MODEW-1:0]         amode,
  input  logic [NREG-1:0]          reg_mask,
  input  logic [AW-1:0]            base_addr,
  output logic                     busy,
  output logic                     bus_req,
  output logic                     bus_we,
  output logic [AW-1:0]            bus_addr,
  output logic [DW-1:0]            bus_wdata,
  input  logic                     bus_ack,
  input  logic [DW-1:0]            bus_rdata,
  output logic [$clog2(NREG)-1:0]  rf_ridx,
  input  logic [2*DW-1:0]          rf_rdata,
  output logic                     rf_we,
  output logic [$clog2(NREG)-1:0]  rf_widx,
  output logic [2*DW-1:0]          rf_wdata,
  output logic                     done,
  output logic [AW-1:0]            final_addr
);

  localparam int IW   = $clog2(NREG);
  localparam int STEP = DW / 8;

  xstate_t         state_q, state_d;
  logic [NREG-1:0] mask_q, mask_d;
  logic            half_q, half_d;
  logic            store_q, long_q, pre_q;
  logic            ctl_en;
  logic            acc;

  logic            pick_any;
  logic [NREG-1:0] pick_bit;
  logic [IW-1:0]   pick_idx;
  logic [NREG-1:0] mask_rest;

  logic            xfer_ack, word_fin;
  logic            addr_load, addr_step;

  assign acc       = (state_q == ST_IDLE) & start;
  assign bus_req   = (state_q == ST_XFER) | (state_q == ST_EXTRA);
  assign bus_we    = (state_q == ST_XFER) & store_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign xfer_ack  = (state_q == ST_XFER) & bus_ack;
  assign word_fin  = xfer_ack & (~long_q | half_q);
  assign mask_rest = mask_q & ~pick_bit;
  assign addr_load = acc;
  assign addr_step = xfer_ack;
  assign rf_ridx   = pick_idx;

  regxfer_pick #(.NREG(NREG), .IW(IW)) u_pick (
    .mask      (mask_q),
    .rev       (pre_q),
    .any       (pick_any),
    .first_bit (pick_bit),
    .reg_idx   (pick_idx)
  );

  regxfer_addr #(.AW(AW), .STEP(STEP)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (addr_load),
    .load_val (base_addr),
    .step_en  (addr_step),
    .down     (pre_q),
    .cur_addr (final_addr),
    .cyc_addr (bus_addr)
  );

  regxfer_lane #(.DW(DW), .IW(IW)) u_lane (
    .clk        (clk),
    .rst_n      (rst_n),
    .long_sz    (long_q),
    .hi_first   (~pre_q),
    .half       (half_q),
    .rf_rdata   (rf_rdata),
    .bus_rdata  (bus_rdata),
    .cap_hi     (xfer_ack & ~store_q & long_q & ~half_q),
    .commit     (word_fin & ~store_q),
    .commit_idx (pick_idx),
    .wdata      (bus_wdata),
    .rf_we      (rf_we),
    .rf_widx    (rf_widx),
    .rf_wdata   (rf_wdata)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    half_d  = half_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          mask_d = reg_mask;
          half_d = 1'b0;
          if (|reg_mask) state_d = ST_XFER;
          else           state_d = to_mem ? ST_DONE : ST_EXTRA;
        end
      end
      ST_XFER: begin
        if (bus_ack) begin
          half_d = long_q & ~half_q;
          if (word_fin) begin
            mask_d = mask_rest;
            if (~|mask_rest) state_d = store_q ? ST_DONE : ST_EXTRA;
          end
        end
      end
      ST_EXTRA: begin
        if (bus_ack) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign ctl_en = acc | bus_req | done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      half_q  <= 1'b0;
    end else if (ctl_en) begin
      state_q <= state_d;
      mask_q  <= mask_d;
      half_q  <= half_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= 1'b0;
      long_q  <= 1'b0;
      pre_q   <= 1'b0;
    end else if (acc) begin
      store_q <= to_mem;
      long_q  <= long_sz;
      pre_q   <= to_mem & (amode == MODE_PREDEC);
    end
  end

  // pick_any is implied by the mask being nonzero in ST_XFER
  logic unused_any;
  assign unused_any = pick_any;

endmodule

// File: rtl/regxfer_seq_chk.sv
module regxfer_seq_chk #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          bus_req,
  input logic          bus_ack,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          rf_we,
  input logic          done
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !done && !rf_we)); // R1

  AST_LOAD_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && !bus_we) |=>
      (!bus_req || bus_we || (bus_addr == $past(bus_addr) + AW'(DW / 8)))); // R2

  AST_RF_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(bus_req && bus_ack && !bus_we)); // R3

  AST_DONE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_req && !rf_we)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we))); // R10

  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !bus_ack) |=> $stable(bus_wdata)); // R10

endmodule

bind regxfer_seq regxfer_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .bus_req   (bus_req),
  .bus_ack   (bus_ack),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rf_we     (rf_we),
  .done      (done)
);

// File: tb/test_regxfer_seq.sv
module test_regxfer_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        to_mem = 1'b0;
  logic        long_sz = 1'b0;
  logic [2:0]  amode = 3'd0;
  logic [15:0] reg_mask = 16'h0;
  logic [31:0] base_addr = 32'h0;
  logic        busy, bus_req, bus_we, rf_we, done;
  logic [31:0] bus_addr, rf_wdata, final_addr, rf_rdata;
  logic [15:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [15:0] bus_rdata = 16'h0;
  logic [3:0]  rf_ridx, rf_widx;

  always #(CLK_PERIOD / 2) clk = ~clk;

  regxfer_seq i_regxfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .to_mem(to_mem), .long_sz(long_sz),
    .amode(amode), .reg_mask(reg_mask), .base_addr(base_addr), .busy(busy),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .rf_ridx(rf_ridx), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata), .done(done),
    .final_addr(final_addr)
  );

  typedef struct {
    int          kind;   // 0 bus cycle, 1 register write, 2 done
    logic [31:0] addr;   // bus address, register index or final address
    logic [31:0] data;
    logic        we;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [15:0] mem[256];
  logic [31:0] brf[16];
  int          vectors = 0;
  int          errors  = 0;
  int          lat     = 0;
  int          waitcnt = 0;
  logic [31:0] hold_addr = 32'h0;

  assign rf_rdata = brf[rf_ridx];

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic push(input int kind, input logic [31:0] a, input logic [31:0] d,
                      input logic we, input string tag);
    exp_t e;
    e.kind = kind; e.addr = a; e.data = d; e.we = we; e.tag = tag;
    q.push_back(e);
  endtask

  function automatic logic [31:0] sext(input logic [15:0] w);
    return {{16{w[15]}}, w};
  endfunction

  // Driver: builds expectations from the requirements, then starts the op
  task automatic run_op(input logic st, input logic lg, input logic [2:0] md,
                        input logic [15:0] mk, input logic [31:0] sa,
                        input int latency, input bit stray);
    logic        pre;
    logic [31:0] a;
    logic [31:0] v;
    string       stag;
    int          t;
    pre  = st && (md == 3'd4);
    a    = sa;
    stag = pre ? "R5" : "R6";
    for (int i = 0; i < 16; i++) begin
      if (mk[i]) begin
        int r;
        r = pre ? 15 - i : i;
        v = brf[r];
        if (st) begin
          if (lg) begin
            if (pre) begin
              push(0, a - 2, {16'h0, v[15:0]},  1'b1, "R7");
              push(0, a - 4, {16'h0, v[31:16]}, 1'b1, stag);
              a = a - 4;
            end else begin
              push(0, a,     {16'h0, v[31:16]}, 1'b1, "R7");
              push(0, a + 2, {16'h0, v[15:0]},  1'b1, stag);
              a = a + 4;
            end
          end else if (pre) begin
            push(0, a - 2, {16'h0, v[15:0]}, 1'b1, stag);
            a = a - 2;
          end else begin
            push(0, a, {16'h0, v[15:0]}, 1'b1, stag);
            a = a + 2;
          end
        end else if (lg) begin
          push(0, a,     32'h0, 1'b0, "R2");
          push(0, a + 2, 32'h0, 1'b0, "R2");
          push(1, r, {mem[a[8:1]], mem[(a + 2) >> 1 & 32'hFF]}, 1'b0, "R7");
          a = a + 4;
        end else begin
          push(0, a, 32'h0, 1'b0, "R2");
          push(1, r, sext(mem[a[8:1]]), 1'b0, "R8");
          a = a + 2;
        end
      end
    end
    if (!st) push(0, a, 32'h0, 1'b0, "R3");
    push(2, a, 32'h0, 1'b0, stray ? "R11" : "R9");

    lat = latency;
    @(negedge clk);
    start = 1'b1; to_mem = st; long_sz = lg; amode = md; reg_mask = mk; base_addr = sa;
    @(negedge clk);
    start = 1'b0;
    if (stray) begin
      repeat (3) @(negedge clk);
      start = 1'b1; to_mem = 1'b1; long_sz = 1'b1; amode = 3'd4;
      reg_mask = 16'hFFFF; base_addr = 32'h1F0;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (q.size() != 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s operation incomplete: got %0d pending expected 0", q[0].tag, q.size());
      q.delete();
    end
    repeat (3) @(negedge clk);
    check("R11", "no activity after done", {29'h0, busy, bus_req, done}, 32'h0);
  endtask

  // Monitor and memory model
  always @(negedge clk) begin
    if (rst_n) begin
      if (rf_we) begin
        if (q.size() == 0 || q[0].kind != 1) begin
          vectors++; errors++;
          $display("FAIL R3 unexpected register write: got idx %0d expected none", rf_widx);
        end else begin
          exp_t e;
          e = q.pop_front();
          check("R4", "register index", {28'h0, rf_widx}, e.addr);
          check(e.tag, "register data", rf_wdata, e.data);
        end
        brf[rf_widx] = rf_wdata;
      end
      if (done) begin
        if (q.size() == 0 || q[0].kind != 2) begin
          vectors++; errors++;
          $display("FAIL R9 unexpected done: got 1 expected 0");
        end else begin
          exp_t e;
          e = q.pop_front();
          check(e.tag, "final address", final_addr, e.addr);
        end
      end
      if (bus_ack) begin
        bus_ack = 1'b0;
      end else if (bus_req) begin
        if (waitcnt == 0) hold_addr = bus_addr;
        else check("R10", "held address", bus_addr, hold_addr);
        if (waitcnt < lat) begin
          waitcnt++;
        end else begin
          waitcnt = 0;
          if (q.size() == 0 || q[0].kind != 0) begin
            vectors++; errors++;
            $display("FAIL R3 unexpected bus cycle: got addr %h expected none", bus_addr);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, "bus address", bus_addr, e.addr);
            check(e.tag, "bus direction", {31'h0, bus_we}, {31'h0, e.we});
            if (e.we) check(e.tag, "bus write data", {16'h0, bus_wdata}, e.data);
          end
          if (bus_we) mem[bus_addr[8:1]] = bus_wdata;
          bus_rdata = mem[bus_addr[8:1]];
          bus_ack = 1'b1;
        end
      end
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {8'(i) ^ 8'hA5, 8'(i)};
    for (int i = 0; i < 16; i++) brf[i] = {8'(i * 17), 8'hC3 ^ 8'(i), 8'(i) + 8'h80, 8'(i)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check("R1", "reset outputs", {28'h0, busy, bus_req, done, rf_we}, 32'h0);

    run_op(1'b0, 1'b0, 3'd3, 16'h8181, 32'h040, 0, 1'b0); // R2 R4 R8 R3
    run_op(1'b0, 1'b1, 3'd5, 16'h0F0F, 32'h080, 1, 1'b0); // R7 long load
    run_op(1'b0, 1'b0, 3'd3, 16'h0000, 32'h020, 0, 1'b0); // R3 empty load
    run_op(1'b1, 1'b0, 3'd4, 16'h00FF, 32'h1C0, 0, 1'b0); // R5 word predec
    run_op(1'b1, 1'b1, 3'd4, 16'hFFFF, 32'h1F0, 2, 1'b0); // R5 R7 long predec
    run_op(1'b1, 1'b0, 3'd2, 16'hA5A5, 32'h100, 1, 1'b0); // R6 word ascending
    run_op(1'b1, 1'b1, 3'd5, 16'h8001, 32'h120, 0, 1'b0); // R6 R7 long ascending
    run_op(1'b1, 1'b0, 3'd4, 16'h0000, 32'h150, 0, 1'b0); // R9 empty store
    run_op(1'b0, 1'b1, 3'd3, 16'hFFFF, 32'h1B0, 0, 1'b0); // R7 read back predec image
    run_op(1'b0, 1'b0, 3'd3, 16'h0003, 32'h010, 2, 1'b1); // R11 stray start
    check("R1", "idle at end", {28'h0, busy, bus_req, done, rf_we}, 32'h0);

    summary();
    $finish;
  end

endmodule